// File: doc/BRIEF.md
# Hysteretic Buck Switch-Timing Controller

This block is the clocked decision logic behind a synchronous step-down converter that regulates by hysteresis rather than by a fixed-frequency ramp. It holds no oscillator. A new switching cycle starts only when the output-voltage comparator reports that the output has dropped below its threshold. The block then turns on the high-side switch for at least a minimum on-time. It hands over to the low-side rectifier after a break-before-make gap. It then keeps the high side off for at least a minimum off-time before a new cycle can begin.

The inputs are comparator flags: output below threshold, high-side over-current, inductor current below the rectifier release level, a converter enable, and a thermal fault. The outputs are the two gate enables and a flag that reports the switch node as undriven. The minimum on-time and off-time are given in nanoseconds and turn into clock cycles at elaboration, using the clock period. The over-current and rectifier-release flags come from fast analog comparators and pass through a two-flop synchroniser before the controller uses them. The feedback flag and the control flags are taken as already synchronous.

Top module: `hbk_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `hs_gate` and `ls_gate` are 0 and `sw_hiz` is 1.
- R2: When `conv_en` is sampled 0, both gates are 0 and `sw_hiz` is 1 from the next cycle on. No gate pulses while it stays 0, whatever the other inputs do.
- R3: When the controller is idle or rectifying, has met its minimum off-time and samples `fb_low`=1, the gates are both 0 for `DEAD_CYC` cycles. `hs_gate` then rises `DEAD_CYC`+1 clock edges after that sample.
- R4: With no over-current, `hs_gate` stays 1 for at least MIN_ON cycles, where MIN_ON = ceil(TON_NS*1000/CLK_PS). After that it stays 1 until `fb_low` is sampled 0. A short `fb_low` request gives a pulse of exactly MIN_ON cycles.
- R5: A 1 on `hs_ilim` ends a high-side pulse at any point, even before MIN_ON has elapsed. `hs_gate` is 0 from the third clock edge after the input changes (two synchroniser flops, then the state register).
- R6: After every high-side pulse, both gates are 0 for exactly `DEAD_CYC` cycles. Then `ls_gate` rises, unless the synchronised `ls_zero` is already 1. In that case the controller goes idle without rectifying.
- R7: `ls_gate` stays 1 until one of these happens. The synchronised `ls_zero` goes to 1: it falls on the third clock edge after the input rises. Or a new high-side start begins: it falls together with the start of the dead time of R3.
- R8: Between two high-side pulses, `hs_gate` is 0 for at least MIN_OFF cycles, where MIN_OFF = ceil(TOFF_NS*1000/CLK_PS). With `fb_low` held at 1, the gap is exactly MIN_OFF+`DEAD_CYC`+1 cycles.
- R9: When `therm_flt` is sampled 1, both gates are 0 and `sw_hiz` is 1 from the next cycle. Nothing switches while the flag stays 1. Switching resumes on demand after it clears.
- R10: `hs_gate` and `ls_gate` are never 1 in the same cycle. Every rising edge of either one follows at least `DEAD_CYC` cycles with both at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_en | input | 1 | Converter enable, 1 = run |
| therm_flt | input | 1 | Thermal fault from the temperature sensor, 1 = too hot |
| fb_low | input | 1 | Feedback comparator, 1 = output below regulation threshold |
| hs_ilim | input | 1 | High-side current above limit (asynchronous) |
| ls_zero | input | 1 | Inductor current below rectifier release level (asynchronous) |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side rectifier enable |
| sw_hiz | output | 1 | Switch node undriven because the converter is disabled or faulted |

## Verification
Each result has a fixed latency. A change on `conv_en` or `therm_flt` reaches the gates one edge later. A change on `hs_ilim` or `ls_zero` reaches them three edges later. A start request on `fb_low` raises `hs_gate` `DEAD_CYC`+1 edges later. The reference model in the bench reproduces these latencies: it shifts the asynchronous flags through its own two-entry delay and updates on the rising edge. It is compared with the outputs at every falling edge. The directed checks count clock edges from the cycle in which a stimulus is driven. They read the gates only at the cycle where the requirement places the change and at the cycle before it. Pulse widths, gaps and dead times are measured as runs of falling-edge samples.

// File: rtl/hbk_pkg.sv
package hbk_pkg;

    // Controller phases; gate enables are decoded from the phase alone.
    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,   // disabled or faulted, node undriven
        PH_IDLE   = 3'd1,   // both off, waiting for a start request
        PH_GAP_HI = 3'd2,   // break-before-make before the high side
        PH_HI     = 3'd3,   // high-side switch conducting
        PH_GAP_LO = 3'd4,   // break-before-make before the rectifier
        PH_LO     = 3'd5    // synchronous rectifier conducting
    } phase_e;

    // Synchronised fast-comparator flags.
    typedef struct packed {
        logic ilim;
        logic zc;
    } cmp_t;

    // Output drive set.
    typedef struct packed {
        logic hs;
        logic ls;
        logic hiz;
    } gate_t;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int cyc_from_ns(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Counter width able to hold values up to and including lim.
    function automatic int cnt_width(input int lim);
        return $clog2(lim + 1) + 1;
    endfunction

endpackage

// File: rtl/hbk_sync.sv
module hbk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbk_offcnt.sv
module hbk_offcnt #(
    parameter int LIMIT = 24,
    parameter int CW    = hbk_pkg::cnt_width(LIMIT)
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_active,
    output logic done
);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Counts high-side-off cycles; starts saturated so the first start is free.
    always_ff @(posedge clk) begin
        if (rst)            cnt <= SAT;
        else if (hs_active) cnt <= '0;
        else if (cnt < SAT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= SAT);
endmodule

// File: rtl/hbk_fsm.sv
module hbk_fsm
    import hbk_pkg::*;
#(
    parameter int MIN_ON = 27,
    parameter int DEAD   = 2,
    parameter int CW     = hbk_pkg::cnt_width(hbk_pkg::max3(MIN_ON, DEAD, 1))
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   fb_low,
    input  logic   off_done,
    input  cmp_t   cmp,
    output phase_e ph
);
    localparam logic [CW-1:0] ON_LAST   = CW'(MIN_ON - 1);
    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD - 1);

    phase_e        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          start_ok;

    assign start_ok = fb_low && off_done;

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        if (!run) begin
            ph_d  = PH_OFF;
            cnt_d = '0;
        end else begin
            unique case (ph_q)
                PH_OFF: begin
                    ph_d  = PH_IDLE;
                    cnt_d = '0;
                end
                PH_IDLE: begin
                    if (start_ok) begin
                        ph_d  = PH_GAP_HI;
                        cnt_d = '0;
                    end
                end
                PH_GAP_HI: begin
                    if (cnt_q == DEAD_LAST) begin
                        ph_d  = PH_HI;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HI: begin
                    if (cmp.ilim || (cnt_q >= ON_LAST && !fb_low)) begin
                        ph_d  = PH_GAP_LO;
                        cnt_d = '0;
                    end else if (cnt_q < ON_LAST) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_GAP_LO: begin
                    if (cnt_q == DEAD_LAST) begin
                        ph_d  = cmp.zc ? PH_IDLE : PH_LO;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_LO: begin
                    cnt_d = '0;
                    if (cmp.zc)        ph_d = PH_IDLE;
                    else if (start_ok) ph_d = PH_GAP_HI;
                end
                default: begin
                    ph_d  = PH_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_OFF;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign ph = ph_q;
endmodule

// File: rtl/hbk_decode.sv
module hbk_decode
    import hbk_pkg::*;
(
    input  phase_e ph,
    output gate_t  g
);
    always_comb begin
        g.hs  = (ph == PH_HI);
        g.ls  = (ph == PH_LO);
        g.hiz = (ph == PH_OFF);
    end
endmodule

// File: rtl/hbk_ctrl.sv
module hbk_ctrl
    import hbk_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int TON_NS      = 107,
    parameter int TOFF_NS     = 95,
    parameter int DEAD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_en,
    input  logic therm_flt,
    input  logic fb_low,
    input  logic hs_ilim,
    input  logic ls_zero,
    output logic hs_gate,
    output logic ls_gate,
    output logic sw_hiz
);
    localparam int MIN_ON  = cyc_from_ns(TON_NS, CLK_PS);
    localparam int MIN_OFF = cyc_from_ns(TOFF_NS, CLK_PS);
    localparam int DEAD    = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int FSM_CW  = cnt_width(max3(MIN_ON, DEAD, 1));
    localparam int OFF_CW  = cnt_width(MIN_OFF);

    cmp_t   cmp_raw, cmp_q;
    phase_e ph;
    gate_t  g;
    logic   off_done;
    logic   run;
    logic   ilim_q, zc_q;

    assign cmp_raw.ilim = hs_ilim;
    assign cmp_raw.zc   = ls_zero;
    assign run          = conv_en && !therm_flt;

    hbk_sync #(.W($bits(cmp_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_raw),
        .q   (cmp_q)
    );

    hbk_offcnt #(.LIMIT(MIN_OFF), .CW(OFF_CW)) u_off (
        .clk       (clk),
        .rst       (rst),
        .hs_active (ph == PH_HI),
        .done      (off_done)
    );

    hbk_fsm #(.MIN_ON(MIN_ON), .DEAD(DEAD), .CW(FSM_CW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .fb_low   (fb_low),
        .off_done (off_done),
        .cmp      (cmp_q),
        .ph       (ph)
    );

    hbk_decode u_dec (
        .ph (ph),
        .g  (g)
    );

    assign ilim_q  = cmp_q.ilim;
    assign zc_q    = cmp_q.zc;
    assign hs_gate = g.hs;
    assign ls_gate = g.ls;
    assign sw_hiz  = g.hiz;
endmodule

// File: rtl/hbk_ctrl_chk.sv
module hbk_ctrl_chk #(
    parameter int MIN_ON  = 27,
    parameter int MIN_OFF = 24,
    parameter int DEAD    = 2
) (
    input logic clk,
    input logic rst,
    input logic conv_en,
    input logic therm_flt,
    input logic fb_low,
    input logic hs_gate,
    input logic ls_gate,
    input logic sw_hiz,
    input logic ilim_s,
    input logic zc_s
);
    localparam int CAP = hbk_pkg::max3(MIN_ON, MIN_OFF, DEAD) + 1;
    localparam int CW  = hbk_pkg::cnt_width(CAP);
    localparam logic [CW-1:0] SAT = CW'(CAP);

    logic [CW-1:0] hi_run, lo_run, both_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run   <= '0;
            lo_run   <= SAT;
            both_off <= SAT;
        end else begin
            hi_run   <= hs_gate ? ((hi_run < SAT) ? hi_run + 1'b1 : SAT) : '0;
            lo_run   <= !hs_gate ? ((lo_run < SAT) ? lo_run + 1'b1 : SAT) : '0;
            both_off <= (!hs_gate && !ls_gate) ? ((both_off < SAT) ? both_off + 1'b1 : SAT) : '0;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!hs_gate && !ls_gate && sw_hiz));

    p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        !conv_en |=> (!hs_gate && !ls_gate && sw_hiz));

    p_hs_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_gate) |-> $past(ilim_s || !fb_low || !conv_en || therm_flt));

    p_short_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(hs_gate) && (hi_run < CW'(MIN_ON))) |-> $past(ilim_s || !conv_en || therm_flt));

    p_ls_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ls_gate) |-> $past(zc_s || fb_low || !conv_en || therm_flt));

    p_min_off_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate) |-> (lo_run >= CW'(MIN_OFF)));

    p_fault_r9: assert property (@(posedge clk) disable iff (rst)
        therm_flt |=> (!hs_gate && !ls_gate && sw_hiz));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

    p_dead_time_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_gate) || $rose(ls_gate)) |-> (both_off >= CW'(DEAD)));
endmodule

bind hbk_ctrl hbk_ctrl_chk #(
    .MIN_ON  (MIN_ON),
    .MIN_OFF (MIN_OFF),
    .DEAD    (DEAD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_en   (conv_en),
    .therm_flt (therm_flt),
    .fb_low    (fb_low),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .sw_hiz    (sw_hiz),
    .ilim_s    (ilim_q),
    .zc_s      (zc_q)
);

// File: tb/tb_hbk_ctrl.sv
`timescale 1ns/1ps
module tb_hbk_ctrl;
    localparam int CLK_PS  = 4000;
    localparam int TON_NS  = 107;
    localparam int TOFF_NS = 95;
    localparam int DEAD    = 2;
    // Bench-side expectations: 107 ns and 95 ns at 4 ns, rounded up.
    localparam int EXP_ON  = (TON_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_OFF = (TOFF_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_en = 1'b0, therm_flt = 1'b0, fb_low = 1'b0;
    logic hs_ilim = 1'b0, ls_zero = 1'b0;
    logic hs_gate, ls_gate, sw_hiz;

    always #2 clk = ~clk;

    hbk_ctrl #(.CLK_PS(CLK_PS), .TON_NS(TON_NS), .TOFF_NS(TOFF_NS),
               .DEAD_CYC(DEAD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .conv_en(conv_en), .therm_flt(therm_flt),
        .fb_low(fb_low), .hs_ilim(hs_ilim), .ls_zero(ls_zero),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .sw_hiz(sw_hiz));

    int n_checks = 0, n_errors = 0;
    int cyc_n = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc_n);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 off, 1 waiting, 2 gap before high side, 3 high side,
    //       4 gap before rectifier, 5 rectifier
    int    mode = 0, tick = 0, since_hi = EXP_OFF;
    bit    dly_il[2] = '{0, 0};
    bit    dly_zc[2] = '{0, 0};
    string why = "R1";
    bit    model_live = 0;

    always @(posedge clk) begin
        bit il, zz, ready;
        int nxt_since;
        cyc_n++;
        il = dly_il[1];
        zz = dly_zc[1];
        dly_il[1] = dly_il[0]; dly_il[0] = hs_ilim;
        dly_zc[1] = dly_zc[0]; dly_zc[0] = ls_zero;
        model_live = 1;
        if (rst) begin
            dly_il = '{0, 0}; dly_zc = '{0, 0};
            mode = 0; tick = 0; since_hi = EXP_OFF; why = "R1";
        end else begin
            nxt_since = (mode == 3) ? 0 : ((since_hi < EXP_OFF) ? since_hi + 1 : EXP_OFF);
            ready = fb_low && (since_hi >= EXP_OFF);
            if (!conv_en || therm_flt) begin
                mode = 0; tick = 0; why = therm_flt ? "R9" : "R2";
            end else if (mode == 0) begin
                mode = 1; tick = 0; why = "R2";
            end else if (mode == 1) begin
                if (ready) begin mode = 2; tick = 0; why = "R3"; end
                else why = "R8";
            end else if (mode == 2) begin
                if (tick == DEAD - 1) begin mode = 3; tick = 0; why = "R3"; end
                else begin tick++; why = "R10"; end
            end else if (mode == 3) begin
                if (il) begin mode = 4; tick = 0; why = "R5"; end
                else if (tick >= EXP_ON - 1 && !fb_low) begin mode = 4; tick = 0; why = "R4"; end
                else begin if (tick < EXP_ON - 1) tick++; why = "R4"; end
            end else if (mode == 4) begin
                if (tick == DEAD - 1) begin mode = zz ? 1 : 5; tick = 0; why = "R6"; end
                else begin tick++; why = "R6"; end
            end else begin
                tick = 0;
                if (zz) begin mode = 1; why = "R7"; end
                else if (ready) begin mode = 2; why = "R7"; end
                else why = "R7";
            end
            since_hi = nxt_since;
        end
    end

    always @(negedge clk) if (model_live && !done_flag) begin
        chk(hs_gate === (mode == 3), why, "hs_gate vs model", int'(hs_gate), int'(mode == 3));
        chk(ls_gate === (mode == 5), why, "ls_gate vs model", int'(ls_gate), int'(mode == 5));
        chk(sw_hiz === (mode == 0), why, "sw_hiz vs model", int'(sw_hiz), int'(mode == 0));
        chk(!(hs_gate && ls_gate), "R10", "gates overlap", int'(hs_gate && ls_gate), 0);
    end

    // ---------------- run-length monitor ----------------
    int hi_len = 0, lo_len = 1000, both_len = 1000;
    int last_hs_w = 0, last_gap = 0, ls_pre = 0, hs_rises = 0, ls_rises = 0, hs_rise_cyc = 0;
    bit p_hs = 0, p_ls = 0;

    always @(negedge clk) begin
        if (hs_gate === 1'b1 && !p_hs) begin hs_rises++; last_gap = lo_len; hs_rise_cyc = cyc_n; end
        if (hs_gate === 1'b0 && p_hs) last_hs_w = hi_len;
        if (ls_gate === 1'b1 && !p_ls) begin ls_rises++; ls_pre = both_len; end
        hi_len   = (hs_gate === 1'b1) ? hi_len + 1 : 0;
        lo_len   = (hs_gate === 1'b1) ? 0 : lo_len + 1;
        both_len = (hs_gate !== 1'b1 && ls_gate !== 1'b1) ? both_len + 1 : 0;
        p_hs = (hs_gate === 1'b1);
        p_ls = (ls_gate === 1'b1);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int c0, r0;
        cyc(3);
        #1;
        chk(hs_gate == 0 && ls_gate == 0, "R1", "gates in reset", int'(hs_gate | ls_gate), 0);
        chk(sw_hiz == 1, "R1", "hiz in reset", int'(sw_hiz), 1);
        @(negedge clk); rst = 0;

        // R2: disabled, inputs wiggle, nothing switches
        for (int i = 0; i < 40; i++) begin
            fb_low = i[0]; hs_ilim = i[2]; ls_zero = i[3];
            @(negedge clk);
        end
        fb_low = 0; hs_ilim = 0; ls_zero = 0;
        cyc(3); #1;
        chk(hs_rises == 0 && ls_rises == 0, "R2", "pulses while disabled", hs_rises + ls_rises, 0);

        // R3/R4/R6: enable, short start request
        conv_en = 1; cyc(5);
        c0 = cyc_n; fb_low = 1; @(negedge clk); fb_low = 0;
        cyc(60); #1;
        chk(hs_rise_cyc == c0 + DEAD + 1, "R3", "start latency", hs_rise_cyc - c0, DEAD + 1);
        chk(last_hs_w == EXP_ON, "R4", "minimum pulse width", last_hs_w, EXP_ON);
        chk(ls_pre == DEAD, "R6", "dead time before rectifier", ls_pre, DEAD);
        chk(ls_gate == 1, "R6", "rectifier on after pulse", int'(ls_gate), 1);

        // R4: long request, R7: rectifier released by the new start
        @(negedge clk); fb_low = 1; cyc(60); fb_low = 0;
        cyc(40); #1;
        chk(last_hs_w == 60 - DEAD, "R4", "pulse held by feedback", last_hs_w, 60 - DEAD);
        chk(ls_gate == 1, "R7", "rectifier holds without zero flag", int'(ls_gate), 1);

        // R7: zero-current release after two sync flops
        @(negedge clk); ls_zero = 1; cyc(2); #1;
        chk(ls_gate == 1, "R7", "rectifier before sync delay", int'(ls_gate), 1);
        cyc(1); #1;
        chk(ls_gate == 0, "R7", "rectifier released", int'(ls_gate), 0);
        @(negedge clk); ls_zero = 0; cyc(10);

        // R5: current limit cuts a pulse short; R8: off-time gap
        fb_low = 1;
        @(posedge hs_gate); @(negedge clk); cyc(4);
        hs_ilim = 1; cyc(2); #1;
        chk(hs_gate == 1, "R5", "high side before sync delay", int'(hs_gate), 1);
        cyc(1); #1;
        chk(hs_gate == 0, "R5", "high side cut by limit", int'(hs_gate), 0);
        chk(last_hs_w == 7, "R5", "limited pulse width", last_hs_w, 7);
        @(negedge clk); hs_ilim = 0;
        @(posedge hs_gate); @(negedge clk); #1;
        chk(last_gap == EXP_OFF + DEAD + 1, "R8", "off gap with request held", last_gap, EXP_OFF + DEAD + 1);
        @(negedge clk); fb_low = 0; cyc(60);

        // R9: thermal fault
        fb_low = 1;
        @(posedge hs_gate); @(negedge clk); cyc(2);
        therm_flt = 1; cyc(1); #1;
        chk(hs_gate == 0 && ls_gate == 0, "R9", "gates off in fault", int'(hs_gate | ls_gate), 0);
        chk(sw_hiz == 1, "R9", "hiz in fault", int'(sw_hiz), 1);
        r0 = hs_rises;
        cyc(12); #1;
        chk(hs_rises == r0, "R9", "no pulse during fault", hs_rises - r0, 0);
        @(negedge clk); therm_flt = 0; cyc(60); #1;
        chk(hs_rises > r0, "R9", "resumes after fault", hs_rises - r0, 1);
        @(negedge clk); fb_low = 0; cyc(40);

        // R2 again: disable while switching
        fb_low = 1; @(posedge hs_gate); @(negedge clk);
        conv_en = 0; cyc(1); #1;
        chk(hs_gate == 0 && sw_hiz == 1, "R2", "disable stops pulse", int'(hs_gate), 0);
        r0 = hs_rises; cyc(30); #1;
        chk(hs_rises == r0, "R2", "no pulse while disabled", hs_rises - r0, 0);
        @(negedge clk); conv_en = 1; fb_low = 0; cyc(20);

        // mixed stimulus, model compared every cycle (R3..R10)
        for (int i = 0; i < 4000; i++) begin
            fb_low    = ($urandom_range(0, 9) < 4);
            hs_ilim   = ($urandom_range(0, 24) == 0);
            ls_zero   = ($urandom_range(0, 14) == 0);
            therm_flt = ($urandom_range(0, 199) == 0);
            conv_en   = ($urandom_range(0, 299) != 0);
            @(negedge clk);
        end
        fb_low = 0; hs_ilim = 0; ls_zero = 0; therm_flt = 0; conv_en = 1;
        cyc(10); #1;
        chk(hs_rises > 20, "R10", "activity in mixed run", hs_rises, 21);
        finish_run();
    end
endmodule